// File: doc/BRIEF.md
# Third-order CIC decimator for a 1-bit delta-sigma stream

This block turns the single-bit output of a delta-sigma modulator into multi-bit words at a reduced rate. It produces the clock that the modulator runs on by dividing the system clock. It takes one data bit on every second falling edge of that clock, which gives one modulator sample per two clock periods. Each bit is fed into a chain of three running-sum stages. After every M samples the last running sum is passed through three first-difference stages, and the result appears as a signed word with a one-cycle strobe.

The ratio M is picked at run time from a 3-bit code and is always a power of two between 4 and 256. All arithmetic wraps in two's complement, and the word is wide enough for the largest ratio, so wraps in the running sums cancel in the differences. Changing the code restarts the filter from an empty state. The first three words after reset, or after a change of code, are held back because the difference stages still hold partial data.

Top module: `cic3_decim`

## Requirements
- R1: While reset is held, and in the first cycle after it, `mod_clk` is 0, `dout_valid` is 0 and `dout` is 0.
- R2: `mod_clk` repeats every CLK_DIV system cycles. In each period it is high for CLK_DIV/2 cycles and then low for CLK_DIV/2 cycles.
- R3: `mod_data` is taken at the system edge where `mod_clk` falls, on alternate falls only, starting with the first fall after reset. A 1 counts as +1 and a 0 counts as 0.
- R4: The ratio is M = 4 << `ratio_sel` for codes 0 to 6 (so 6 gives 256). Code 7 also gives 256.
- R5: Let j be the index of the M-th, 2M-th, … sample captured since the last clear. The word for sample j equals the sum over n = 0 … 3M−3 of h[n]·x[j−n]. Here h[n] is the coefficient of z^−n in (1 + z^−1 + … + z^−(M−1))^3, and samples taken before the clear count as 0.
- R6: Words are 26-bit two's complement. Integrator overflow wraps with no saturation and has no effect on the result, and a run of all ones at M = 256 gives exactly 2^24.
- R7: `dout_valid` is a single-cycle pulse. It rises two system cycles after the capture edge of the sample that completes a block of M, and `dout` holds the new word in that same cycle.
- R8: No strobe is given for the first three blocks after reset or after a change of `ratio_sel`. From the fourth block on, every block gives one strobe.
- R9: A change of `ratio_sel` clears the filter state. Words after the change depend only on bits captured after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_data | input | 1 | Serial bit from the modulator |
| ratio_sel | input | 3 | Decimation-ratio code |
| mod_clk | output | 1 | Clock sent to the modulator |
| dout | output | 26 | Filtered, decimated word (signed) |
| dout_valid | output | 1 | One-cycle strobe marking a new word |

## Verification
A falling edge of `mod_clk` is visible at the port one system edge after it is registered. For every capture edge it sees, the bench records the cycle number. The word for a completed block is due exactly two cycles after that capture edge. The bench samples at the falling system-clock edge, so it expects the strobe in exactly that cycle and checks the value against a direct convolution with the triple-boxcar kernel. A strobe that comes early, comes late or was never due is reported as a failure. The bench also checks the clock's period and high time in system cycles, and it changes the ratio only on a non-capture fall so that each restart begins cleanly.

// File: rtl/cic3_pkg.sv
// Shared constants for the third-order CIC decimator.
// Assumes ratios are powers of two from 2^MIN_LOG up to 2^MAX_LOG.
package cic3_pkg;
    localparam int NSTG    = 3;                      // filter order
    localparam int MIN_LOG = 2;                      // smallest ratio 4
    localparam int MAX_LOG = 8;                      // largest ratio 256
    localparam int CODE_W  = 3;                      // ratio code width
    localparam int IN_W    = 2;                      // 0/+1 as a signed word
    localparam int ACC_W   = IN_W + NSTG * MAX_LOG;  // 26 bits
    localparam int CNT_W   = MAX_LOG;                // sample counter width
    localparam int FILL_N  = NSTG;                   // blocks held back

    typedef logic signed [ACC_W-1:0] acc_t;

    // log2 of the ratio for a code; codes past the top clamp to MAX_LOG
    function automatic int ratio_log(input logic [CODE_W-1:0] code);
        int l;
        l = int'(code) + MIN_LOG;
        return (l > MAX_LOG) ? MAX_LOG : l;
    endfunction
endpackage

// File: rtl/cic3_mclk_gen.sv
// Modulator clock generator and bit capture.
// Divides clk by DIV (even, >= 2). The clock is high for DIV/2 cycles, then low.
// On alternate falls, beginning with the first fall after reset, it registers
// data_i and raises smp_o for one cycle.
module cic3_mclk_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_i,
    output logic mclk_o,
    output logic bit_o,
    output logic smp_o
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] MID  = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          phase_q;
    logic          fall;

    // the clock falls at this edge
    assign fall = (cnt_q == MID) && mclk_o;

    // divider, phase toggle and bit capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            mclk_o  <= 1'b0;
            phase_q <= 1'b0;
            bit_o   <= 1'b0;
            smp_o   <= 1'b0;
        end else begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            if (cnt_q == LAST)
                mclk_o <= 1'b1;
            else if (cnt_q == MID)
                mclk_o <= 1'b0;
            smp_o <= fall && !phase_q;
            if (fall)
                phase_q <= ~phase_q;
            if (fall && !phase_q)
                bit_o <= data_i;
        end
    end

    // R3: a capture pulse follows a fall of the modulator clock
    a_r3_capture_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        smp_o |-> (!mclk_o && $past(mclk_o)));

    // R3: capture pulses last one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        smp_o |=> !smp_o);
endmodule

// File: rtl/cic3_integ.sv
// Three running-sum stages, one update per modulator sample.
// Each stage adds the new value of the stage before it in the same cycle,
// so the last sum already includes the current bit. Sums wrap.
module cic3_integ
    import cic3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic smp_i,
    input  logic bit_i,
    output acc_t acc_o
);
    acc_t acc_q [NSTG];
    acc_t nxt   [NSTG];

    // chain of next-state sums
    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign nxt[g] = acc_q[g] + {{(ACC_W-1){1'b0}}, bit_i};
        end else begin : g_rest
            assign nxt[g] = acc_q[g] + nxt[g-1];
        end
    end

    // update all stages on a sample, clear on reset or ratio change
    always_ff @(posedge clk) begin
        for (int s = 0; s < NSTG; s++) begin
            if (!rst_n || clr_i)
                acc_q[s] <= '0;
            else if (smp_i)
                acc_q[s] <= nxt[s];
        end
    end

    assign acc_o = acc_q[NSTG-1];

    // R5: the sum moves only on a sample
    a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_i && !clr_i) |=> $stable(acc_o));

    // R9: a clear empties the chain
    a_r9_integ_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_o == '0));
endmodule

// File: rtl/cic3_comb.sv
// Decimation counter and three first-difference stages.
// Counts samples. After the sample that completes a block of M, it flags the
// block, and one cycle later takes the running sum and updates the differences.
// The strobe is held back until FILL_N blocks have gone through.
module cic3_comb
    import cic3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              smp_i,
    input  logic [CODE_W-1:0] code_i,
    input  acc_t              acc_i,
    output acc_t              dout_o,
    output logic              valid_o
);
    localparam int FW = $clog2(FILL_N + 1);

    logic [CNT_W-1:0] mlast;
    logic [CNT_W-1:0] dcnt_q;
    logic             dec_q;
    logic [FW-1:0]    fill_q;
    acc_t             z_q  [NSTG];
    acc_t             diff [NSTG];

    // last count value of a block for the selected ratio
    assign mlast = CNT_W'((32'd1 << ratio_log(code_i)) - 32'd1);

    // difference chain
    for (genvar g = 0; g < NSTG; g++) begin : g_diff
        if (g == 0) begin : g_first
            assign diff[g] = acc_i - z_q[g];
        end else begin : g_rest
            assign diff[g] = diff[g-1] - z_q[g];
        end
    end

    // block counting, difference update and strobe
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            dcnt_q  <= '0;
            dec_q   <= 1'b0;
            fill_q  <= '0;
            dout_o  <= '0;
            valid_o <= 1'b0;
            for (int s = 0; s < NSTG; s++) z_q[s] <= '0;
        end else begin
            if (smp_i)
                dcnt_q <= (dcnt_q == mlast) ? '0 : dcnt_q + 1'b1;
            dec_q   <= smp_i && (dcnt_q == mlast);
            valid_o <= 1'b0;
            if (dec_q) begin
                z_q[0] <= acc_i;
                for (int s = 1; s < NSTG; s++) z_q[s] <= diff[s-1];
                dout_o  <= diff[NSTG-1];
                valid_o <= (fill_q == FW'(FILL_N));
                if (fill_q != FW'(FILL_N))
                    fill_q <= fill_q + 1'b1;
            end
        end
    end

    // R7: the strobe is a one-cycle pulse
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R4: the sample counter stays inside the selected block length
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        dcnt_q <= mlast);

    // R7: a strobe comes only from a flagged block
    a_r7_valid_after_block: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(dec_q));
endmodule

// File: rtl/cic3_decim.sv
// Top of the third-order CIC decimator.
// Generates the modulator clock, captures bits, integrates, decimates by
// a run-time ratio and differentiates. A change of ratio code clears the filter.
module cic3_decim
    import cic3_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mod_data,
    input  logic [CODE_W-1:0]       ratio_sel,
    output logic                    mod_clk,
    output logic signed [ACC_W-1:0] dout,
    output logic                    dout_valid
);
    logic              smp;
    logic              cap_bit;
    logic              clr;
    logic [CODE_W-1:0] ratio_q;
    acc_t              isum;
    acc_t              word;

    // remember the code so a change can be seen
    always_ff @(posedge clk) begin
        ratio_q <= ratio_sel;
    end

    assign clr = rst_n && (ratio_sel != ratio_q);

    cic3_mclk_gen #(.DIV(CLK_DIV)) mclk_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .data_i (mod_data),
        .mclk_o (mod_clk),
        .bit_o  (cap_bit),
        .smp_o  (smp)
    );

    cic3_integ integ_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .smp_i (smp),
        .bit_i (cap_bit),
        .acc_o (isum)
    );

    cic3_comb comb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .smp_i   (smp),
        .code_i  (ratio_sel),
        .acc_i   (isum),
        .dout_o  (word),
        .valid_o (dout_valid)
    );

    assign dout = word;

    // R9: no strobe right after a ratio change
    a_r9_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !dout_valid);

    // R1: outputs are quiet in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!dout_valid && !mod_clk));
endmodule

// File: tb/cic3_decim_tb.sv
// Bench for cic3_decim: random and directed bit streams over all ratio codes.
// Results are compared with a direct convolution computed in the bench.
module cic3_decim_tb_top;
    localparam int DIV   = 4;
    localparam int W     = 26;
    localparam int LIMIT = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mod_data = 1'b0;
    logic [2:0]   ratio_sel = 3'd0;
    logic         mod_clk;
    logic [W-1:0] dout;
    logic         dout_valid;

    int     errors = 0;
    int     checks = 0;
    longint cyc = 0;

    int     xs[$];
    longint h[];
    int     m_cur = 4;
    int     s_cnt = 0;
    int     fall_cnt = 0;
    bit     prev_mclk = 1'b0;
    bit     fell_last = 1'b0;
    bit     cap_last = 1'b0;
    longint last_rise = -1;
    int     r2n = 0;
    bit     pend = 1'b0;
    longint due = 0;
    longint pend_val = 0;
    string  tag = "R3";
    int     mode = 0;
    int     dens = 50;
    int     alt = 0;

    cic3_decim #(.CLK_DIV(DIV)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mod_data   (mod_data),
        .ratio_sel  (ratio_sel),
        .mod_clk    (mod_clk),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // watchdog: an overrun counts as a failed check
    always @(negedge clk) begin
        if (cyc > LIMIT) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog: actual cycles=%0d expected below %0d", cyc, LIMIT);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // kernel: coefficients of the cube of an M-tap boxcar
    function automatic void build_h(input int m);
        h = new[3 * m - 2];
        for (int n = 0; n < 3 * m - 2; n++) begin
            longint c = 0;
            for (int a = 0; a < m; a++) begin
                int lo = n - a - (m - 1);
                int hi = n - a;
                if (lo < 0) lo = 0;
                if (hi > m - 1) hi = m - 1;
                if (hi >= lo) c += hi - lo + 1;
            end
            h[n] = c;
        end
    endfunction

    function automatic longint conv();
        longint sum = 0;
        for (int n = 0; n < 3 * m_cur - 2; n++) begin
            int idx = xs.size() - 1 - n;
            if (idx >= 0) sum += h[n] * xs[idx];
        end
        return sum;
    endfunction

    function automatic int next_bit();
        case (mode)
            1: return 1;
            2: return 0;
            3: begin alt = 1 - alt; return alt; end
            default: return (($urandom % 100) < dens) ? 1 : 0;
        endcase
    endfunction

    // one system cycle, observed at the falling clk edge
    task automatic step();
        bit rose, fell;
        @(negedge clk);
        if (dout_valid) begin
            if (pend && cyc == due)
                chk(longint'($signed(dout)) == pend_val, tag, longint'($signed(dout)), pend_val);
            else
                chk(1'b0, "R8 strobe not due", cyc, due);
            pend = 1'b0;
        end else if (pend && cyc > due) begin
            chk(1'b0, "R7 strobe missing", cyc, due);
            pend = 1'b0;
        end
        rose = !prev_mclk && mod_clk;
        fell = prev_mclk && !mod_clk;
        prev_mclk = mod_clk;
        fell_last = fell;
        cap_last = 1'b0;
        if (rose) begin
            if (last_rise >= 0 && r2n < 6) begin
                chk(cyc - last_rise == DIV, "R2 period", cyc - last_rise, DIV);
                r2n++;
            end
            last_rise = cyc;
        end
        if (fell) begin
            if (last_rise >= 0 && r2n < 6)
                chk(cyc - last_rise == DIV / 2, "R2 high time", cyc - last_rise, DIV / 2);
            fall_cnt++;
            if (fall_cnt % 2 == 1) begin
                cap_last = 1'b1;
                xs.push_back(int'(mod_data));
                s_cnt++;
                if (s_cnt % m_cur == 0 && s_cnt / m_cur >= 4) begin
                    pend = 1'b1;
                    due = cyc + 2;
                    pend_val = conv();
                end
                mod_data = 1'(next_bit());
            end
        end
    endtask

    // one run at a code: nout strobed words after the three held back
    task automatic seg(input int code, input int md, input int dn, input int nout,
                       input string t, input bit first);
        if (!first) begin
            do step(); while (!(fell_last && !cap_last));
            ratio_sel = 3'(code);
        end
        xs.delete();
        s_cnt = 0;
        pend = 1'b0;
        mode = md;
        dens = dn;
        tag = t;
        m_cur = (code >= 6) ? 256 : (4 << code);
        build_h(m_cur);
        if (first) mod_data = 1'(next_bit());
        while (s_cnt < (nout + 3) * m_cur || pend) step();
    endtask

    initial begin
        void'($urandom(32'd4242));
        ratio_sel = 3'd0;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(mod_clk == 1'b0, "R1 mod_clk", longint'(mod_clk), 0);
        chk(dout_valid == 1'b0, "R1 valid", longint'(dout_valid), 0);
        chk(dout == '0, "R1 dout", longint'(dout), 0);
        rst_n = 1'b1;
        // R3: random bits, capture phase from the first fall
        seg(0, 0, 50, 40, "R3", 1'b1);
        // R5: alternating and random streams at several ratios
        seg(1, 3, 50, 8, "R5", 1'b0);
        seg(2, 0, 20, 8, "R5", 1'b0);
        seg(3, 0, 80, 6, "R5", 1'b0);
        seg(4, 0, 50, 5, "R5", 1'b0);
        seg(5, 0, 65, 4, "R5", 1'b0);
        // R6: full scale at the largest ratio is exactly 2^24
        seg(6, 1, 0, 3, "R6", 1'b0);
        // R9: after a full-scale run, zeros must give zero words
        seg(2, 2, 0, 4, "R9", 1'b0);
        // R6: long random run at 256 wraps the running sums
        seg(6, 0, 90, 8, "R6", 1'b0);
        // R4: code 7 behaves as ratio 256
        seg(7, 1, 0, 2, "R4", 1'b0);
        repeat (10) step();
        summary();
        $finish;
    end
endmodule